// File: doc/BRIEF.md
# Shared-Memory FIFO Channel Access Engine

This engine is a bus master. It lets a hardware coprocessor exchange data with a FIFO channel that lives entirely in shared memory, so software tasks and other hardware tasks can use the same channel. The engine holds no FIFO storage of its own. The coprocessor gives it one request: the direction, blocking or non-blocking mode, an item count, the item size in 32-bit words, the channel depth in items, and three word addresses (the lock word, the status block and the data buffer). The engine then runs a guarded transaction on a word-wide memory master port.

Each transaction is a strict sequence of accesses:
1. It takes the lock with an atomic test-and-set read, repeating the read while the lock is held.
2. It reads the three status words.
3. It moves as many whole items as fit (write direction) or are present (read direction).
4. It writes the updated status back.
5. It releases the lock by writing zero.

A non-blocking request ends after one transaction and reports how many items it moved, which may be zero. A blocking request repeats whole transactions, always releasing the lock in between, until the full count has been moved.

The memory port and both coprocessor data streams use valid/ready handshakes:
- Memory port: a request is taken in a cycle where `mem_valid` and `mem_ready` are both high. Read data is sampled in that same cycle. A request held against low `mem_ready` keeps its address and direction unchanged.
- Data stream into the channel: `src_valid` must stay high until `src_ready` accepts the word.
- Data stream out of the channel: `dst_valid` and `dst_data` stay stable until `dst_ready` is high.

Top module: `shfifo_xfer`

## Requirements
- R1: Every transaction issues, in this order and with nothing else in between:
  - one lock read at the lock address;
  - three status reads at status base +0 (stored item count), +1 (read item index) and +2 (write item index);
  - the data words;
  - three status writes to the same three words;
  - one write of 0 to the lock address.
- R2: A lock read returning nonzero means the lock is held by someone else. The engine then repeats the lock read, and makes no other access, until a read returns 0.
- R3: After moving n items, the status written back is:
  - write direction: count + n, and the write index advanced by n modulo depth;
  - read direction: count - n, and the read index advanced by n modulo depth;
  - the other index is left unchanged.
- R4: A non-blocking request moves min(requested, free items) when writing, or min(requested, stored items) when reading. `done_count` reports that number, which may be 0. A zero-item transaction still writes the status back and releases the lock.
- R5: A blocking request repeats complete transactions until the requested count has been moved, then reports it in `done_count`. The lock is released before every retry.
- R6: Data word w of the item at index p is at buffer base + p*item_words + w. Items go in index order, and index depth-1 is followed by index 0.
- R7: In the write direction, each memory write carries the next `src_data` word. `src_ready` is high only in the cycle the memory accepts that word.
- R8: In the read direction, each word read is presented on `dst_data` in order. `dst_valid` and `dst_data` hold until `dst_ready` is high.
- R9: At most one memory access is outstanding. A request not yet accepted keeps `mem_valid`, `mem_addr` and `mem_write` stable.
- R10: `req_ready` is high only while idle. `done` is a single-cycle pulse per request, with `done_count` valid in that cycle.
- R11: During and after reset the engine is idle: `req_ready` is 1, `mem_valid` is 0, `done` is 0, and no lock is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request accepted when both high |
| req_write | input | 1 | 1: write into channel, 0: read from channel |
| req_block | input | 1 | 1: blocking, 0: non-blocking |
| req_count | input | CW | Items requested |
| req_item_words | input | IWW | Item size in 32-bit words (nonzero) |
| req_depth | input | CW | Channel depth in items (nonzero) |
| req_lock_addr | input | AW | Word address of the lock |
| req_stat_addr | input | AW | Word address of the status block |
| req_buf_addr | input | AW | Word address of the data buffer |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | CW | Items moved by the finished request |
| src_valid | input | 1 | Coprocessor word available for writing |
| src_ready | output | 1 | Coprocessor word consumed |
| src_data | input | DW | Word to write into the channel |
| dst_valid | output | 1 | Word read from the channel available |
| dst_ready | input | 1 | Coprocessor takes the word |
| dst_data | output | DW | Word read from the channel |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_write | output | 1 | 1: write, 0: read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid in the accepting cycle |

## Verification
The bench checks each corner case by comparing the engine's memory access trace with an expected one.

- Buffer wrap: a write that starts two items before the end of the buffer must continue from index 0. A walker that does not wrap would run off the end of the buffer instead.
- Partial and empty reads: a non-blocking read asks for more items than are stored, and another finds the channel empty. A wrong `min` would report or move the wrong count. A design that skips the bookkeeping for zero items would leave the lock held.
- Lock contention: the lock is held for three attempts. Any status access during that window shows the engine did not wait for the lock.
- Full channel with blocking write: the bench empties the channel each time the lock is released. A design that retried while holding the lock would hang, and one that forgot the moved total would report the wrong count.

Memory and output-stream back-pressure are drawn from a pseudo-random pattern. This exposes any request that changes before it is accepted.

// File: rtl/shfifo_pkg.sv
package shfifo_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOCK,
    ST_SREAD,
    ST_CALC,
    ST_DATA,
    ST_PUSH,
    ST_SWRITE,
    ST_UNLOCK,
    ST_DONE
  } xfer_state_e;

  // word offsets inside the status block
  localparam int unsigned STAT_CNT  = 0;
  localparam int unsigned STAT_RIDX = 1;
  localparam int unsigned STAT_WIDX = 2;
  localparam int unsigned STAT_LAST = 2;

endpackage

// File: rtl/shfifo_stat_calc.sv
// Combinational: how many items this round can move and what the status becomes.
module shfifo_stat_calc #(
  parameter int unsigned CW = 16
) (
  input  logic          dir_wr,
  input  logic [CW-1:0] remain,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] ridx,
  input  logic [CW-1:0] widx,
  input  logic [CW-1:0] depth,
  output logic [CW-1:0] n_items,
  output logic [CW-1:0] start_idx,
  output logic [CW-1:0] new_cnt,
  output logic [CW-1:0] new_ridx,
  output logic [CW-1:0] new_widx
);
  logic [CW-1:0] avail;
  logic [CW:0]   sum;
  logic [CW-1:0] adv;

  always_comb begin
    avail     = dir_wr ? (depth - cnt) : cnt;
    n_items   = (remain < avail) ? remain : avail;
    start_idx = dir_wr ? widx : ridx;
    sum       = {1'b0, start_idx} + {1'b0, n_items};
    if (sum >= {1'b0, depth}) adv = CW'(sum - {1'b0, depth});
    else                      adv = sum[CW-1:0];
    new_cnt  = dir_wr ? (cnt + n_items) : (cnt - n_items);
    new_ridx = dir_wr ? ridx : adv;
    new_widx = dir_wr ? adv  : widx;
  end
endmodule

// File: rtl/shfifo_addr_walk.sv
// Walks buffer word addresses item by item, wrapping the item index at depth.
module shfifo_addr_walk #(
  parameter int unsigned AW  = 16,
  parameter int unsigned CW  = 16,
  parameter int unsigned IWW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [AW-1:0]  base,
  input  logic [CW-1:0]  start_idx,
  input  logic [CW-1:0]  depth,
  input  logic [IWW-1:0] item_words,
  input  logic [CW-1:0]  items,
  output logic [AW-1:0]  addr,
  output logic           last,
  output logic           empty
);
  logic [AW-1:0]  base_r;
  logic [CW-1:0]  idx_r;
  logic [CW-1:0]  depth_r;
  logic [CW-1:0]  left_r;
  logic [IWW-1:0] iw_r;
  logic [IWW-1:0] word_r;
  logic           item_end;

  assign item_end = (word_r == iw_r - IWW'(1));
  assign addr  = base_r + AW'(idx_r) * AW'(iw_r) + AW'(word_r);
  assign last  = (left_r == CW'(1)) && item_end;
  assign empty = (left_r == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_r  <= '0;
      idx_r   <= '0;
      depth_r <= '0;
      left_r  <= '0;
      iw_r    <= '0;
      word_r  <= '0;
    end else if (load) begin
      base_r  <= base;
      idx_r   <= start_idx;
      depth_r <= depth;
      left_r  <= items;
      iw_r    <= item_words;
      word_r  <= '0;
    end else if (step) begin
      if (item_end) begin
        word_r <= '0;
        left_r <= left_r - CW'(1);
        idx_r  <= (idx_r == depth_r - CW'(1)) ? '0 : idx_r + CW'(1);
      end else begin
        word_r <= word_r + IWW'(1);
      end
    end
  end

  // R6: never step past the last item, and the index stays inside the buffer
  a_r6_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !empty);
  a_r6_index_below_depth: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> (idx_r < depth_r));
endmodule

// File: rtl/shfifo_xfer.sv
module shfifo_xfer
  import shfifo_pkg::*;
#(
  parameter int unsigned AW  = 16,
  parameter int unsigned DW  = 32,
  parameter int unsigned CW  = 16,
  parameter int unsigned IWW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic           req_block,
  input  logic [CW-1:0]  req_count,
  input  logic [IWW-1:0] req_item_words,
  input  logic [CW-1:0]  req_depth,
  input  logic [AW-1:0]  req_lock_addr,
  input  logic [AW-1:0]  req_stat_addr,
  input  logic [AW-1:0]  req_buf_addr,
  output logic           done,
  output logic [CW-1:0]  done_count,
  input  logic           src_valid,
  output logic           src_ready,
  input  logic [DW-1:0]  src_data,
  output logic           dst_valid,
  input  logic           dst_ready,
  output logic [DW-1:0]  dst_data,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic           mem_write,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata
);
  localparam int unsigned SIW = 2;

  xfer_state_e    st;
  logic           dir_wr_r, blk_r, lock_held, last_r;
  logic [CW-1:0]  remain_r, total_r, moved_r, n_r;
  logic [CW-1:0]  cnt_r, ridx_r, widx_r, ncnt_r, nridx_r, nwidx_r, depth_r;
  logic [IWW-1:0] iw_r;
  logic [AW-1:0]  lock_r, stat_r, buf_r;
  logic [SIW-1:0] sidx;
  logic [DW-1:0]  hold_r;
  logic           fire;

  logic [CW-1:0] c_n, c_start, c_cnt, c_ridx, c_widx;
  logic [AW-1:0] w_addr;
  logic          w_last, w_empty;

  shfifo_stat_calc #(.CW(CW)) u_calc (
    .dir_wr(dir_wr_r), .remain(remain_r), .cnt(cnt_r), .ridx(ridx_r),
    .widx(widx_r), .depth(depth_r), .n_items(c_n), .start_idx(c_start),
    .new_cnt(c_cnt), .new_ridx(c_ridx), .new_widx(c_widx)
  );

  shfifo_addr_walk #(.AW(AW), .CW(CW), .IWW(IWW)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .load(st == ST_CALC),
    .step(st == ST_DATA && fire),
    .base(buf_r), .start_idx(c_start), .depth(depth_r),
    .item_words(iw_r), .items(c_n),
    .addr(w_addr), .last(w_last), .empty(w_empty)
  );

  // memory request steering
  always_comb begin
    mem_valid = 1'b0;
    mem_write = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      ST_LOCK: begin
        mem_valid = 1'b1;
        mem_addr  = lock_r;
      end
      ST_SREAD: begin
        mem_valid = 1'b1;
        mem_addr  = stat_r + AW'(sidx);
      end
      ST_DATA: begin
        mem_addr  = w_addr;
        mem_write = dir_wr_r;
        mem_valid = dir_wr_r ? src_valid : 1'b1;
        mem_wdata = dir_wr_r ? src_data : '0;
      end
      ST_SWRITE: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = stat_r + AW'(sidx);
        if (sidx == SIW'(STAT_CNT))       mem_wdata = DW'(ncnt_r);
        else if (sidx == SIW'(STAT_RIDX)) mem_wdata = DW'(nridx_r);
        else                              mem_wdata = DW'(nwidx_r);
      end
      ST_UNLOCK: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = lock_r;
      end
      default: ;
    endcase
  end

  assign fire       = mem_valid && mem_ready;
  assign req_ready  = (st == ST_IDLE);
  assign src_ready  = (st == ST_DATA) && dir_wr_r && mem_ready;
  assign dst_valid  = (st == ST_PUSH);
  assign dst_data   = hold_r;
  assign done       = (st == ST_DONE);
  assign done_count = moved_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      dir_wr_r  <= 1'b0;
      blk_r     <= 1'b0;
      lock_held <= 1'b0;
      last_r    <= 1'b0;
      remain_r  <= '0;
      total_r   <= '0;
      moved_r   <= '0;
      n_r       <= '0;
      cnt_r     <= '0;
      ridx_r    <= '0;
      widx_r    <= '0;
      ncnt_r    <= '0;
      nridx_r   <= '0;
      nwidx_r   <= '0;
      depth_r   <= '0;
      iw_r      <= '0;
      lock_r    <= '0;
      stat_r    <= '0;
      buf_r     <= '0;
      sidx      <= '0;
      hold_r    <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          dir_wr_r <= req_write;
          blk_r    <= req_block;
          remain_r <= req_count;
          total_r  <= req_count;
          moved_r  <= '0;
          iw_r     <= req_item_words;
          depth_r  <= req_depth;
          lock_r   <= req_lock_addr;
          stat_r   <= req_stat_addr;
          buf_r    <= req_buf_addr;
          st       <= ST_LOCK;
        end
        ST_LOCK: if (fire && mem_rdata == '0) begin
          lock_held <= 1'b1;
          sidx      <= '0;
          st        <= ST_SREAD;
        end
        ST_SREAD: if (fire) begin
          if (sidx == SIW'(STAT_CNT))       cnt_r  <= mem_rdata[CW-1:0];
          else if (sidx == SIW'(STAT_RIDX)) ridx_r <= mem_rdata[CW-1:0];
          else                              widx_r <= mem_rdata[CW-1:0];
          if (sidx == SIW'(STAT_LAST)) st <= ST_CALC;
          else                         sidx <= sidx + SIW'(1);
        end
        ST_CALC: begin
          n_r     <= c_n;
          ncnt_r  <= c_cnt;
          nridx_r <= c_ridx;
          nwidx_r <= c_widx;
          sidx    <= '0;
          st      <= (c_n == '0) ? ST_SWRITE : ST_DATA;
        end
        ST_DATA: if (fire) begin
          if (dir_wr_r) begin
            if (w_last) st <= ST_SWRITE;
          end else begin
            hold_r <= mem_rdata;
            last_r <= w_last;
            st     <= ST_PUSH;
          end
        end
        ST_PUSH: if (dst_ready) st <= last_r ? ST_SWRITE : ST_DATA;
        ST_SWRITE: if (fire) begin
          if (sidx == SIW'(STAT_LAST)) st <= ST_UNLOCK;
          else                         sidx <= sidx + SIW'(1);
        end
        ST_UNLOCK: if (fire) begin
          lock_held <= 1'b0;
          moved_r   <= moved_r + n_r;
          remain_r  <= remain_r - n_r;
          st        <= (blk_r && (remain_r != n_r)) ? ST_LOCK : ST_DONE;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9: a request waiting for the memory keeps its address and direction
  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !(st == ST_DATA && dir_wr_r))
      |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));
  // R8: an output word is held until taken
  a_r8_dst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_data)));
  // R2/R5: never spin on the lock while already owning it
  a_r2_no_spin_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOCK) |-> !lock_held);
  // R1: status and data accesses only happen under the lock
  a_r1_access_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && st != ST_LOCK) |-> lock_held);
  // R3: the written-back count never exceeds the depth
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SWRITE) |-> (ncnt_r <= depth_r));
  // R5: a blocking request reports its full count
  a_r5_block_complete: assert property (@(posedge clk) disable iff (!rst_n)
    (done && blk_r) |-> (done_count == total_r));
  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11: after reset no lock is held and the bus is quiet
  a_r11_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!mem_valid && !lock_held && req_ready));
endmodule

// File: tb/sim_shfifo_xfer.sv
module sim_shfifo_xfer;
  localparam int AW = 16, DW = 32, CW = 16, IWW = 4;
  localparam int LOCK = 8'h10, STAT = 8'h20, BUF = 8'h40;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_write = 0, req_block = 0;
  logic [CW-1:0] req_count = '0, req_depth = '0;
  logic [IWW-1:0] req_item_words = '0;
  logic req_ready, done, src_ready, dst_valid, mem_valid, mem_write;
  logic dst_ready = 0, mem_ready = 0;
  logic [CW-1:0] done_count;
  logic [DW-1:0] src_data, dst_data, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic src_valid;

  shfifo_xfer #(.AW(AW), .DW(DW), .CW(CW), .IWW(IWW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_block(req_block), .req_count(req_count),
    .req_item_words(req_item_words), .req_depth(req_depth),
    .req_lock_addr(AW'(LOCK)), .req_stat_addr(AW'(STAT)), .req_buf_addr(AW'(BUF)),
    .done(done), .done_count(done_count),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_data(dst_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // memory model with test-and-set lock, contention and a draining consumer
  logic [DW-1:0] mem [0:255];
  int spin_left = 0;
  bit drain_en = 0;
  logic [7:0] tr_a [0:511];
  logic       tr_w [0:511];
  logic [DW-1:0] tr_d [0:511];
  int tr_n = 0;
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) if (mem_valid && mem_ready) begin
    tr_a[tr_n] <= mem_addr[7:0];
    tr_w[tr_n] <= mem_write;
    tr_d[tr_n] <= mem_write ? mem_wdata : mem_rdata;
    tr_n <= tr_n + 1;
    if (mem_write) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_addr[7:0] == 8'(LOCK) && drain_en) begin
        mem[STAT] <= '0;
        mem[STAT+1] <= mem[STAT+2];
      end
    end else if (mem_addr[7:0] == 8'(LOCK)) begin
      if (mem[LOCK] != 0 && spin_left > 0) begin
        spin_left <= spin_left - 1;
        if (spin_left == 1) mem[LOCK] <= '0;
      end else mem[LOCK] <= 32'd1;
    end
  end

  // source and sink streams
  logic [DW-1:0] src_arr [0:63];
  logic [DW-1:0] dst_arr [0:63];
  int src_idx = 0, src_len = 0, dst_n = 0;
  assign src_valid = (src_idx < src_len);
  assign src_data  = src_arr[src_idx & 63];
  always @(posedge clk) begin
    if (src_valid && src_ready) src_idx <= src_idx + 1;
    if (dst_valid && dst_ready) begin
      dst_arr[dst_n & 63] <= dst_data;
      dst_n <= dst_n + 1;
    end
  end

  // protocol monitors
  int hold_err = 0, dst_err = 0, dbl_done = 0, done_n = 0;
  logic [CW-1:0] got_cnt = '0;
  logic pend = 0, dpend = 0, pdone = 0, pwe = 0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pdst = '0;
  always @(posedge clk) begin
    if (pend && (!mem_valid || mem_addr != paddr || mem_write != pwe)) hold_err <= hold_err + 1;
    if (dpend && (!dst_valid || dst_data != pdst)) dst_err <= dst_err + 1;
    pend  <= mem_valid && !mem_ready;
    paddr <= mem_addr;
    pwe   <= mem_write;
    dpend <= dst_valid && !dst_ready;
    pdst  <= dst_data;
    if (done) begin done_n <= done_n + 1; got_cnt <= done_count; end
    if (done && pdone) dbl_done <= dbl_done + 1;
    pdone <= done;
  end

  // pseudo-random back-pressure
  logic [15:0] lfsr = 16'hACE1;
  initial forever begin
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = lfsr[0] | lfsr[3];
    dst_ready = lfsr[5] | lfsr[7];
  end

  int cyc = 0;
  bit wd_hit = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic set_status(input int c, input int r, input int w);
    mem[STAT] = 32'(c); mem[STAT+1] = 32'(r); mem[STAT+2] = 32'(w);
  endtask

  task automatic issue(input bit wr, input bit blk, input int cnt, input int iw, input int dep);
    int d0;
    d0 = done_n;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_block = blk;
    req_count = CW'(cnt); req_item_words = IWW'(iw); req_depth = CW'(dep);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R10 busy after accept", req_ready, 0);
    while (done_n == d0 && cyc < 150000) @(negedge clk);
    if (done_n == d0) begin
      wd_hit = 1;
      chk(0, "R5 watchdog", 0, 1);
    end
    repeat (2) @(negedge clk);
    chk(done_n == d0 + 1 && dbl_done == 0, "R10 single done pulse", done_n - d0, 1);
  endtask

  // check one complete transaction in the trace
  task automatic chk_xact(input string tg, inout int i, input bit wr, input int p0,
                          input int n, input int iw, input int dep,
                          input int nc, input int nr, input int nw, inout int sref);
    bit ok;
    int p;
    chk(tr_a[i] == 8'(LOCK) && !tr_w[i] && tr_d[i] == 0, {"R1 lock read ", tg}, tr_a[i], LOCK);
    i++;
    ok = 1;
    for (int k = 0; k < 3; k++) if (tr_a[i+k] != 8'(STAT+k) || tr_w[i+k]) ok = 0;
    chk(ok, {"R1 status reads ", tg}, tr_a[i], STAT);
    i += 3;
    ok = 1;
    p = p0;
    for (int j = 0; j < n; j++) begin
      for (int w = 0; w < iw; w++) begin
        if (tr_a[i] != 8'(BUF + p*iw + w) || tr_w[i] != wr) ok = 0;
        if (wr ? (tr_d[i] != src_arr[sref & 63]) : (dst_arr[sref & 63] != tr_d[i])) begin
          chk(0, wr ? {"R7 word ", tg} : {"R8 word ", tg}, tr_d[i], wr ? src_arr[sref & 63] : dst_arr[sref & 63]);
        end
        sref++; i++;
      end
      p = (p + 1) % dep;
    end
    chk(ok, {"R6 data addresses ", tg}, tr_a[i-1], BUF);
    chk(tr_a[i] == 8'(STAT) && tr_w[i] && tr_d[i] == 32'(nc), {"R3 count writeback ", tg}, tr_d[i], nc);
    chk(tr_a[i+1] == 8'(STAT+1) && tr_w[i+1] && tr_d[i+1] == 32'(nr), {"R3 read index ", tg}, tr_d[i+1], nr);
    chk(tr_a[i+2] == 8'(STAT+2) && tr_w[i+2] && tr_d[i+2] == 32'(nw), {"R3 write index ", tg}, tr_d[i+2], nw);
    i += 3;
    chk(tr_a[i] == 8'(LOCK) && tr_w[i] && tr_d[i] == 0, {"R1 release ", tg}, tr_a[i], LOCK);
    i++;
  endtask

  task automatic t_reset();
    chk(req_ready && !mem_valid && !done, "R11 idle after reset", {req_ready, mem_valid, done}, 3'b100);
  endtask

  task automatic t_write_wrap();
    int i, s;
    i = tr_n; s = src_idx;
    set_status(0, 2, 2);
    for (int k = 0; k < 6; k++) src_arr[(src_len + k) & 63] = 32'hA000_0000 + 32'(k);
    src_len = src_len + 6;
    issue(1, 0, 3, 2, 4);
    chk(got_cnt == 3, "R4 write count", got_cnt, 3);
    chk_xact("wrap write", i, 1, 2, 3, 2, 4, 3, 2, 1, s);
    chk(tr_n == i, "R1 access total", tr_n, i);
    chk(src_idx == src_len, "R7 words consumed", src_idx, src_len);
  endtask

  task automatic t_read_partial();
    int i, s;
    i = tr_n; s = dst_n;
    issue(0, 0, 5, 2, 4);
    chk(got_cnt == 3, "R4 partial read count", got_cnt, 3);
    chk_xact("partial read", i, 0, 2, 3, 2, 4, 0, 1, 1, s);
    chk(dst_arr[0] == 32'hA000_0000 && dst_arr[5] == 32'hA000_0005, "R8 read order", dst_arr[5], 32'hA000_0005);
  endtask

  task automatic t_read_empty();
    int i, s;
    i = tr_n; s = dst_n;
    issue(0, 0, 2, 2, 4);
    chk(got_cnt == 0, "R4 empty read count", got_cnt, 0);
    chk_xact("empty read", i, 0, 1, 0, 2, 4, 0, 1, 1, s);
    chk(mem[LOCK] == 0, "R4 lock free after empty read", mem[LOCK], 0);
  endtask

  task automatic t_spin();
    int i, s;
    bit ok;
    i = tr_n; s = src_idx;
    mem[LOCK] = 32'd1; spin_left = 3;
    src_arr[src_len & 63] = 32'hB1; src_arr[(src_len + 1) & 63] = 32'hB2;
    src_len = src_len + 2;
    issue(1, 0, 1, 2, 4);
    ok = 1;
    for (int k = 0; k < 3; k++) if (tr_a[i+k] != 8'(LOCK) || tr_w[i+k] || tr_d[i+k] == 0) ok = 0;
    chk(ok, "R2 spin only on lock", tr_a[i+2], LOCK);
    i += 3;
    chk_xact("after spin", i, 1, 1, 1, 2, 4, 1, 1, 2, s);
  endtask

  task automatic t_block_write();
    int i, s;
    i = tr_n; s = src_idx;
    set_status(4, 0, 0);
    drain_en = 1;
    for (int k = 0; k < 6; k++) src_arr[(src_len + k) & 63] = 32'hC000_0000 + 32'(k);
    src_len = src_len + 6;
    issue(1, 1, 6, 1, 4);
    drain_en = 0;
    chk(got_cnt == 6, "R5 blocking total", got_cnt, 6);
    chk_xact("block round1 full", i, 1, 0, 0, 1, 4, 4, 0, 0, s);
    chk_xact("block round2", i, 1, 0, 4, 1, 4, 4, 0, 0, s);
    chk_xact("block round3", i, 1, 0, 2, 1, 4, 2, 0, 2, s);
    chk(tr_n == i, "R5 three rounds only", tr_n, i);
  endtask

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_write_wrap();
    t_read_partial();
    t_read_empty();
    t_spin();
    t_block_write();
    chk(hold_err == 0, "R9 request stable until accepted", hold_err, 0);
    chk(dst_err == 0, "R8 output held until taken", dst_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #900000;
    n_chk++; n_fail++;
    $display("FAIL R5 watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule